// File: doc/BRIEF.md
# Per-Phase Memory Wait-State Generator

This block lengthens a three-phase external memory bus cycle, made of phases T1, T2 and T3, for accesses to a mid-range memory region. Each phase can be stretched by its own programmed number of wait states. A bus controller raises `req` while the block is idle. The request carries an area bit, which selects between two mid-range sub-areas, and a scheme bit, which selects the chip-select arrangement. From the next clock onward the block reports the current phase, marks the stretched clocks as wait states, and pulses `done` in the last clock of the cycle.

Two 8-bit configuration registers hold the wait counts. They sit on a small register port with synchronous writes and combinational reads. Under the first chip-select scheme, each sub-area has its own register. Under the second scheme, the register at 0x0A covers the whole region and the register at 0x0B is ignored. The selected counts are captured when a cycle starts, so the register port can be rewritten while a cycle runs without disturbing it.

Top module: `mwait_gen`

## Requirements
- R1: After reset, both configuration registers read 0xFF. In the same state `phase` is 0 (idle) and `busy`, `wait_st` and `done` are low.
- R2: A write with `reg_we` high to address 0x0A (register A) or 0x0B (register B) takes effect at the clock edge. From the following cycle, a read at that address returns the written byte.
- R3: Reads at any other address return 0x00. Writes to any other address change neither register.
- R4: Register layout: bits 7:5 give the T1 wait count (0..7), bits 4:3 the T2 wait count (0..3), and bits 2:0 the T3 wait count (0..7). A phase with wait count N lasts N+1 clocks.
- R5: `phase` encodes idle=0, T1=1, T2=2, T3=3. A cycle enters T1 on the clock after a request is accepted, passes through T2 and T3 in that order, and then returns to idle.
- R6: A cycle keeps `busy` high for exactly 3 + T1 + T2 + T3 clocks.
- R7: With `cs_scheme`=0, `req_area`=0 uses register A and `req_area`=1 uses register B.
- R8: With `cs_scheme`=1, register A governs both areas, and the contents of register B have no effect.
- R9: The wait counts are captured when the request is accepted. A register write during an active cycle changes only later cycles.
- R10: `done` is high for exactly one clock, the last clock of T3. A request is accepted only in idle, and a `req` held high during a cycle does not restart or extend it.
- R11: `wait_st` is low in the first clock of each phase and high in every later clock of that phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register port address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| req | input | 1 | Access request, sampled in idle |
| req_area | input | 1 | Mid-range sub-area of the request (0 or 1) |
| cs_scheme | input | 1 | Chip-select scheme: 0 = per-area registers, 1 = single register |
| busy | output | 1 | High while a cycle is active |
| phase | output | 2 | Current phase: 0 idle, 1 T1, 2 T2, 3 T3 |
| wait_st | output | 1 | Current clock is an inserted wait state |
| done | output | 1 | Last clock of the cycle |

## Verification
A corrupted down-counter or a wrong latched count changes the length of a phase. The error is therefore visible at `phase` within at most eight clocks of that phase starting, and it also moves `done` off the predicted clock. A wrong register selection shows up in the very next cycle as a total length that matches the other register's value. The bench makes this visible by loading the two registers with complementary bytes. A bad transition in the phase state appears at once as an out-of-order `phase` value or as a wait flag on a phase's first clock. Sweeping all 256 register values under every area and scheme combination covers every count for every phase.

// File: rtl/mwait_pkg.sv
package mwait_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2,
        PH_T3   = 2'd3
    } phase_e;
endpackage

// File: rtl/mwait_regs.sv
// Two configuration registers with a write port and a combinational read mux.
module mwait_regs #(
    parameter int              ADDR_W   = 8,
    parameter int              CFG_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_A = 8'h0A,
    parameter logic [ADDR_W-1:0] ADDR_B = 8'h0B,
    parameter logic [CFG_W-1:0]  RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    output logic [CFG_W-1:0]  cfg_a,
    output logic [CFG_W-1:0]  cfg_b
);
    localparam int NREG = 2;
    localparam logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {ADDR_B, ADDR_A};

    typedef struct packed {
        logic [NREG-1:0][CFG_W-1:0] cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NREG; i++) begin
            if (reg_we && (reg_addr == REG_ADDR[i])) begin
                r_d.cfg[i] = reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cfg <= {NREG{RST_VAL}};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (reg_addr == REG_ADDR[i]) begin
                reg_rdata = r_q.cfg[i];
            end
        end
    end

    assign cfg_a = r_q.cfg[0];
    assign cfg_b = r_q.cfg[1];
endmodule

// File: rtl/mwait_sel.sv
// Picks the governing register from sub-area and chip-select scheme.
module mwait_sel #(
    parameter int CFG_W = 8
) (
    input  logic [CFG_W-1:0] cfg_a,
    input  logic [CFG_W-1:0] cfg_b,
    input  logic             req_area,
    input  logic             cs_scheme,
    output logic [CFG_W-1:0] cfg_sel
);
    always_comb begin
        if (!cs_scheme && req_area) begin
            cfg_sel = cfg_b;
        end else begin
            cfg_sel = cfg_a;
        end
    end
endmodule

// File: rtl/mwait_seq.sv
// Phase sequencer: T1, T2, T3, each followed by its captured wait count.
module mwait_seq
    import mwait_pkg::*;
#(
    parameter int T1_W = 3,
    parameter int T2_W = 2,
    parameter int T3_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [T1_W+T2_W+T3_W-1:0]  cfg,
    input  logic                       req,
    output logic [1:0]                 phase,
    output logic                       wait_st,
    output logic                       done,
    output logic                       busy
);
    localparam int CFG_W  = T1_W + T2_W + T3_W;
    localparam int W12    = (T1_W > T2_W) ? T1_W : T2_W;
    localparam int CNT_W  = (W12 > T3_W) ? W12 : T3_W;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [T2_W-1:0]   t2;
        logic [T3_W-1:0]   t3;
        logic              wt;
    } seq_t;

    seq_t s_d, s_q;

    logic [T1_W-1:0] f_t1;
    logic [T2_W-1:0] f_t2;
    logic [T3_W-1:0] f_t3;

    assign f_t1 = cfg[CFG_W-1 -: T1_W];
    assign f_t2 = cfg[T3_W +: T2_W];
    assign f_t3 = cfg[0 +: T3_W];

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.wt = 1'b0;
                if (req) begin
                    s_d.ph  = PH_T1;
                    s_d.cnt = CNT_W'(f_t1);
                    s_d.t2  = f_t2;
                    s_d.t3  = f_t3;
                end
            end
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                    s_d.wt  = 1'b1;
                end else begin
                    s_d.wt = 1'b0;
                    unique case (s_q.ph)
                        PH_T1: begin
                            s_d.ph  = PH_T2;
                            s_d.cnt = CNT_W'(s_q.t2);
                        end
                        PH_T2: begin
                            s_d.ph  = PH_T3;
                            s_d.cnt = CNT_W'(s_q.t3);
                        end
                        default: begin
                            s_d.ph  = PH_IDLE;
                            s_d.cnt = '0;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, cnt: '0, t2: '0, t3: '0, wt: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.ph;
    assign wait_st = s_q.wt;
    assign busy    = (s_q.ph != PH_IDLE);
    assign done    = (s_q.ph == PH_T3) && (s_q.cnt == '0);
endmodule

// File: rtl/mwait_gen.sv
module mwait_gen #(
    parameter int              ADDR_W = 8,
    parameter int              T1_W   = 3,
    parameter int              T2_W   = 2,
    parameter int              T3_W   = 3,
    parameter logic [ADDR_W-1:0] ADDR_A = 8'h0A,
    parameter logic [ADDR_W-1:0] ADDR_B = 8'h0B
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_we,
    input  logic [T1_W+T2_W+T3_W-1:0]  reg_wdata,
    output logic [T1_W+T2_W+T3_W-1:0]  reg_rdata,
    input  logic                       req,
    input  logic                       req_area,
    input  logic                       cs_scheme,
    output logic                       busy,
    output logic [1:0]                 phase,
    output logic                       wait_st,
    output logic                       done
);
    localparam int CFG_W = T1_W + T2_W + T3_W;

    logic [CFG_W-1:0] cfg_a, cfg_b, cfg_sel;

    mwait_regs #(
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W),
        .ADDR_A (ADDR_A),
        .ADDR_B (ADDR_B),
        .RST_VAL({CFG_W{1'b1}})
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b)
    );

    mwait_sel #(.CFG_W(CFG_W)) u_sel (
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .req_area (req_area),
        .cs_scheme(cs_scheme),
        .cfg_sel  (cfg_sel)
    );

    mwait_seq #(.T1_W(T1_W), .T2_W(T2_W), .T3_W(T3_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg_sel),
        .req    (req),
        .phase  (phase),
        .wait_st(wait_st),
        .done   (done),
        .busy   (busy)
    );
endmodule

// File: rtl/mwait_chk.sv
module mwait_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase,
    input logic       wait_st,
    input logic       done
);
    AST_DONE_IN_T3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == 2'd3)); // R10
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (phase == 2'd0)); // R10
    AST_T1_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |=> (phase == 2'd1 || phase == 2'd2)); // R5
    AST_T2_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase == 2'd2 || phase == 2'd3)); // R5
    AST_IDLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase == 2'd0 || phase == 2'd1)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |-> (!wait_st && !done)); // R1
    AST_FIRST_NOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |-> !wait_st); // R11
endmodule

bind mwait_gen mwait_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .wait_st(wait_st),
    .done   (done)
);

// File: tb/tb_mwait_gen.sv
`timescale 1ns/1ps
module tb_mwait_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       req = 1'b0;
    logic       req_area = 1'b0;
    logic       cs_scheme = 1'b0;
    logic       busy;
    logic [1:0] phase;
    logic       wait_st;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mwait_gen dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req),
        .req_area(req_area), .cs_scheme(cs_scheme), .busy(busy),
        .phase(phase), .wait_st(wait_st), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string rq);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, rq, reg_rdata, exp);
    endtask

    // Runs one access and checks every phase against the expected byte.
    task automatic run(input bit area, input bit scheme, input logic [7:0] exp_cfg,
                       input string mode_rq, input bit hold,
                       input bit mid_wr, input logic [7:0] mid_data);
        int len [4];
        int waits = 0, ndone = 0, done_pos = -1, total = 0;
        int bad_first = 0, bad_order = 0, guard = 0;
        logic [1:0] prev = 2'd0;
        int e1, e2, e3;
        e1 = exp_cfg[7:5] + 1; e2 = exp_cfg[4:3] + 1; e3 = exp_cfg[2:0] + 1;
        for (int i = 0; i < 4; i++) len[i] = 0;
        @(negedge clk);
        req_area = area; cs_scheme = scheme; req = 1'b1;
        @(negedge clk);
        if (!hold) req = 1'b0;
        if (mid_wr) begin
            reg_addr = 8'h0A; reg_wdata = mid_data; reg_we = 1'b1;
        end
        while (phase != 2'd0 && guard < 64) begin
            total++;
            len[phase]++;
            if (phase < prev) bad_order++;
            if (phase != prev && wait_st) bad_first++;
            if (wait_st) waits++;
            if (done) begin ndone++; done_pos = total; end
            prev = phase;
            guard++;
            @(negedge clk);
            reg_we = 1'b0;
        end
        req = 1'b0;
        reg_we = 1'b0;
        chk(len[1] == e1, "R4 T1 length", len[1], e1);
        chk(len[2] == e2, "R4 T2 length", len[2], e2);
        chk(len[3] == e3, "R4 T3 length", len[3], e3);
        chk(total == e1 + e2 + e3, "R6 total length", total, e1 + e2 + e3);
        chk(total == e1 + e2 + e3, mode_rq, total, e1 + e2 + e3);
        chk(bad_order == 0 && prev == 2'd3, "R5 phase order", bad_order, 0);
        chk(ndone == 1 && done_pos == total, "R10 done pulse", done_pos, total);
        chk(waits == e1 + e2 + e3 - 3 && bad_first == 0, "R11 wait flags", waits, e1 + e2 + e3 - 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(phase == 2'd0 && !busy && !wait_st && !done, "R1 idle outputs", phase, 0);
        rd_chk(8'h0A, 8'hFF, "R1 reg A reset");
        rd_chk(8'h0B, 8'hFF, "R1 reg B reset");
        run(1'b0, 1'b0, 8'hFF, "R1 max waits", 1'b0, 1'b0, 8'h00);

        // R2 write and read back
        wr(8'h0A, 8'h5A);
        rd_chk(8'h0A, 8'h5A, "R2 reg A readback");
        wr(8'h0B, 8'hC3);
        rd_chk(8'h0B, 8'hC3, "R2 reg B readback");

        // R3 unmapped addresses
        wr(8'h0C, 8'h00);
        wr(8'h09, 8'h11);
        rd_chk(8'h0C, 8'h00, "R3 unmapped read");
        rd_chk(8'h09, 8'h00, "R3 unmapped read");
        rd_chk(8'h0A, 8'h5A, "R3 reg A untouched");
        rd_chk(8'h0B, 8'hC3, "R3 reg B untouched");
        run(1'b1, 1'b0, 8'hC3, "R3 cycle unchanged", 1'b0, 1'b0, 8'h00);

        // R9 write during a cycle only affects the next one
        wr(8'h0A, 8'h00);
        run(1'b0, 1'b0, 8'h00, "R9 captured counts", 1'b0, 1'b1, 8'hFF);
        rd_chk(8'h0A, 8'hFF, "R9 write landed");
        run(1'b0, 1'b0, 8'hFF, "R9 next cycle", 1'b0, 1'b0, 8'h00);

        // R10 held request does not restart
        wr(8'h0A, 8'h49);
        run(1'b0, 1'b0, 8'h49, "R10 held req", 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        chk(phase == 2'd0 && !busy, "R10 stays idle", phase, 0);

        // Sweep of every register value under all area/scheme combinations
        for (int v = 0; v < 256; v++) begin
            wr(8'h0A, 8'(v));
            wr(8'h0B, ~8'(v));
            run(1'b0, 1'b0, 8'(v), "R7 area0 reg A", 1'b0, 1'b0, 8'h00);
            run(1'b1, 1'b0, ~8'(v), "R7 area1 reg B", 1'b0, 1'b0, 8'h00);
            run(1'b1, 1'b1, 8'(v), "R8 scheme2 area1 reg A", 1'b0, 1'b0, 8'h00);
            run(1'b0, 1'b1, 8'(v), "R8 scheme2 area0 reg A", 1'b0, 1'b0, 8'h00);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule